// File: doc/BRIEF.md
# Edge-Latched One-Time-Programmable ROM

This block is a cycle-level, synthesizable model of a 2048-word by 8-bit fuse memory. Each cell starts blank (reads 0) and can be blown to 1 once, never back. The chip-enable input is sampled on a system clock. Its falling edge latches the address into the device, so the external address bus is free to move afterwards. Read data is presented a fixed, parameterised number of clock edges later. This stands in for the access time of a real part.

The eight data lines are modelled as three plain ports. The first is the value the device would drive. The second is a drive-enable that stands for the non-high-impedance state. The third is the level the lines carry from outside, which defaults to all ones through pull-ups. A bit is programmed by holding exactly one data line low while a falling edge on the program-enable input arrives. At that moment chip enable must be low and output enable high. The selected bit is ORed into the latched word.

Top module: `otp_rom`

## Requirements
- R1: After reset every one of the 2048 words reads as 8'h00, and the drive-enable `q_en` is 0.
- R2: The address is latched by the first clock edge that sees `ce_n` low after seeing it high. Changes on `addr` after that edge do not alter the word that is read.
- R3: `q_en` stays 0 after the latching edge and becomes 1 after LATENCY further clock edges (default 2), provided `ce_n` and `oe_n` stay low.
- R4: Once the read is ready, `q_en` follows `oe_n` at once: it is 0 while `oe_n` is 1 and 1 while `oe_n` is 0. While `q_en` is 1, `q_out` carries the stored word.
- R5: While `ce_n` is 1, `q_en` is 0 whatever `oe_n` is.
- R6: A program pulse is accepted when all of these hold at the clock edge that first sees `pgm_n` low after it was high: `ce_n` is low, an address is latched, `oe_n` is high, and exactly one bit of `q_in` is 0. An accepted pulse sets that bit position (q_in bit i low sets data bit i) in the latched word.
- R7: Programming only sets bits. Bits already 1 stay 1, other bits and other words are unchanged, and re-programming a set bit has no effect.
- R8: A pulse during which `q_in` has no bit low, or two or more bits low, changes nothing.
- R9: A pulse while `oe_n` is low changes nothing.
- R10: One low period of `pgm_n` programs at most one bit. A change of `q_in` while `pgm_n` stays low is ignored.
- R11: Address bits [10:4] pick one of 128 rows and bits [3:0] pick one of 16 byte columns in a 128 x 128 cell array. Every address reaches its own distinct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; blanks the array |
| addr | input | 11 | Word address, latched on chip-enable fall |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program enable; its falling edge is a program pulse |
| q_in | input | 8 | Level on the data lines from outside; one low line selects the bit to program |
| q_out | output | 8 | Value driven on the data lines (0 when not driven) |
| q_en | output | 1 | 1 when the data lines are driven, 0 for high impedance |

## Verification
The hardest conditions to reach from the ports are the rejected program pulses. These are a pulse held low across a change of the data lines, a pulse with several or no lines low, and a pulse while the outputs are enabled. Each leaves no visible trace except through a later read. The stimulus builds each of these pulses by hand on its own fresh address and then reads that word back. In every read, the bench also drives the inverted address right after the latching edge, so a design that used the live bus would return the wrong word. A full sweep then programs a computed bit pattern into all 2048 words and reads every word back.

// File: rtl/otp_pkg.sv
package otp_pkg;
  parameter int ADDR_W = 11;
  parameter int DATA_W = 8;
  parameter int ROW_W  = 7;

  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int ROW_BITS = COLS * DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [COL_W-1:0]  col_t;

  // upper address bits choose the row of the cell matrix
  function automatic row_t row_of(addr_t a);
    return a[ADDR_W-1:COL_W];
  endfunction

  // lower address bits choose the byte column inside a row
  function automatic col_t col_of(addr_t a);
    return a[COL_W-1:0];
  endfunction

  // a line pulled low selects the bit to blow
  function automatic word_t lines_to_mask(word_t lines);
    return ~lines;
  endfunction

  function automatic logic single_low(word_t lines);
    return $countones(~lines) == 1;
  endfunction
endpackage

// File: rtl/otp_edge_ctrl.sv
module otp_edge_ctrl
  import otp_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  pgm_n,
  input  addr_t addr,
  output addr_t addr_q,
  output logic  armed,
  output logic  ready,
  output logic  ce_fall,
  output logic  pgm_fall
);
  localparam int CNT_W = $clog2(LATENCY + 2);

  logic             ce_q;
  logic             pgm_q;
  logic [CNT_W-1:0] wait_cnt;

  assign ce_fall  = ce_q & ~ce_n;
  assign pgm_fall = pgm_q & ~pgm_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      pgm_q    <= 1'b1;
      armed    <= 1'b0;
      addr_q   <= '0;
      wait_cnt <= '0;
    end else begin
      ce_q  <= ce_n;
      pgm_q <= pgm_n;
      if (ce_n) begin
        armed <= 1'b0;
      end else if (ce_fall) begin
        armed    <= 1'b1;
        addr_q   <= addr;
        wait_cnt <= CNT_W'(LATENCY);
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  assign ready = armed & ~ce_n & (wait_cnt == '0);

  // R2: latched address moves only on a chip-enable fall
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(addr_q));

  // R5: no read is ready without a latched cycle
  assert_ready_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> armed);

  generate
    if (LATENCY > 0) begin : g_lat
      // R3: data is not ready on the edge right after latching
      assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_fall |=> !ready);
    end
  endgenerate
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr_q,
  input  logic  we,
  input  word_t mask,
  output word_t rd_word
);
  logic [ROW_BITS-1:0] cells [ROWS];
  row_t row_sel;
  col_t col_sel;

  assign row_sel = row_of(addr_q);
  assign col_sel = col_of(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (we) begin
      cells[row_sel][int'(col_sel)*DATA_W +: DATA_W] <=
        cells[row_sel][int'(col_sel)*DATA_W +: DATA_W] | mask;
    end
  end

  assign rd_word = cells[row_sel][int'(col_sel)*DATA_W +: DATA_W];

  // R7: a write never clears a bit of the addressed word
  assert_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((rd_word & $past(rd_word)) == $past(rd_word)));

  // R6: the selected bit reads back as 1 after the write
  assert_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((rd_word & $past(mask)) == $past(mask)));
endmodule

// File: rtl/otp_rom.sv
module otp_rom
  import otp_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic [DATA_W-1:0] q_in,
  output logic [DATA_W-1:0] q_out,
  output logic              q_en
);
  addr_t addr_q;
  logic  armed;
  logic  ready;
  logic  ce_fall;
  logic  pgm_fall;
  logic  prog_we;
  word_t rd_word;

  otp_edge_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .pgm_n    (pgm_n),
    .addr     (addr),
    .addr_q   (addr_q),
    .armed    (armed),
    .ready    (ready),
    .ce_fall  (ce_fall),
    .pgm_fall (pgm_fall)
  );

  assign prog_we = pgm_fall & armed & ~ce_n & oe_n & single_low(q_in);

  otp_fuse_array u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_q  (addr_q),
    .we      (prog_we),
    .mask    (lines_to_mask(q_in)),
    .rd_word (rd_word)
  );

  assign q_en  = ready & ~oe_n;
  assign q_out = q_en ? rd_word : '0;

  // R5: deselected device never drives
  assert_hiz_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !q_en);

  // R9: a blow only happens with the data lines released
  assert_prog_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> !q_en);

  // R10: consecutive edges cannot both program
  assert_one_per_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> !prog_we);
endmodule

// File: tb/tb_otp_rom.sv
module tb_otp_rom;
  localparam int LAT = 2;
  localparam int NW  = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic        ce_n, oe_n, pgm_n;
  logic [7:0]  q_in;
  logic [7:0]  q_out;
  logic        q_en;

  int checks = 0;
  int failures = 0;
  logic [7:0] expm [NW];

  always #2 clk = ~clk;

  otp_rom #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .q_in(q_in), .q_out(q_out), .q_en(q_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // latch address a, move the bus away, then check latency and data
  task automatic do_read(input int a, input string req);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; pgm_n = 1'b1; q_in = 8'hFF;
    @(negedge clk); addr = a[10:0]; ce_n = 1'b0;
    @(negedge clk); addr = ~addr;
    for (int k = 0; k < LAT; k++) begin
      chk("R3 not ready", {31'd0, q_en}, 32'd0);
      @(negedge clk);
    end
    chk("R3 ready", {31'd0, q_en}, 32'd1);
    chk(req, {24'd0, q_out}, {24'd0, expm[a]});
  endtask

  task automatic do_prog(input int a, input logic [7:0] lines, input logic oe_v);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; q_in = 8'hFF;
    @(negedge clk); addr = a[10:0]; ce_n = 1'b0; oe_n = oe_v;
    @(negedge clk); q_in = lines; pgm_n = 1'b0;
    @(negedge clk); pgm_n = 1'b1; q_in = 8'hFF;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog act=timeout exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) expm[i] = 8'h00;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; q_in = 8'hFF; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset q_en", {31'd0, q_en}, 32'd0);

    // R1: blank after reset
    for (int a = 0; a < NW; a++) do_read(a, "R1 blank");

    // R4: output enable gates the drive once ready
    do_read(5, "R2 latched read");
    oe_n = 1'b1; #1;
    chk("R4 oe high", {31'd0, q_en}, 32'd0);
    oe_n = 1'b0; #1;
    chk("R4 oe low", {31'd0, q_en}, 32'd1);
    // R5: chip enable high forces high impedance
    ce_n = 1'b1; #1;
    chk("R5 ce high", {31'd0, q_en}, 32'd0);

    // R6: single bit program
    do_prog(100, ~8'h04, 1'b1); expm[100] |= 8'h04;
    do_read(100, "R6 program bit2");
    // R7: re-program and add a bit
    do_prog(100, ~8'h04, 1'b1);
    do_read(100, "R7 reprogram set bit");
    do_prog(100, ~8'h80, 1'b1); expm[100] |= 8'h80;
    do_read(100, "R7 add bit keeps old");
    do_read(101, "R7 neighbour untouched");

    // R8: no line low, two lines low
    do_prog(200, 8'hFF, 1'b1);
    do_read(200, "R8 no line low");
    do_prog(200, 8'hF3, 1'b1);
    do_read(200, "R8 two lines low");

    // R9: outputs enabled during pulse
    do_prog(300, ~8'h01, 1'b0);
    do_read(300, "R9 pulse with oe low");

    // R10: lines change while pgm_n held low
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; q_in = 8'hFF;
    @(negedge clk); addr = 11'd400; ce_n = 1'b0;
    @(negedge clk); q_in = ~8'h02; pgm_n = 1'b0;
    @(negedge clk); q_in = ~8'h40;
    @(negedge clk); q_in = ~8'h08;
    @(negedge clk); pgm_n = 1'b1; q_in = 8'hFF;
    expm[400] |= 8'h02;
    do_read(400, "R10 single bit per pulse");

    // R11: row versus column selection
    do_prog(16'h010, ~8'h08, 1'b1); expm[16'h010] |= 8'h08;
    do_prog(16'h001, ~8'h20, 1'b1); expm[16'h001] |= 8'h20;
    do_read(16'h000, "R11 origin");
    do_read(16'h010, "R11 row1 col0");
    do_read(16'h001, "R11 row0 col1");

    // full sweep: computed pattern into every word
    for (int a = 0; a < NW; a++) begin
      int b;
      logic [7:0] m;
      b = (a ^ (a >> 4)) & 7;
      m = 8'h01 << b;
      do_prog(a, ~m, 1'b1); expm[a] |= m;
      if (a % 3 == 0) begin
        m = 8'h01 << ((b + 5) & 7);
        do_prog(a, ~m, 1'b1); expm[a] |= m;
      end
    end
    for (int a = 0; a < NW; a++) do_read(a, "R11 sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule